// File: doc/BRIEF.md
# Dual Time-Match Alarm Controller

This block watches the current time and two programmed alarm times. On every time-update strobe it compares the current time with each alarm time. When an armed alarm matches, it raises that alarm's status flag and sends a one-cycle interrupt pulse. Software clears both flags through a single strobe, which marks the clearing clock of a status read.

Two behaviours are available. In one-shot mode, each enabled alarm fires on its first match and then disarms. It stays disarmed until its enable is dropped and set again. In repeating mode, an enabled alarm fires on every match. In repeating mode, alarm 0 takes precedence: when both enables are set, alarm 1 is silenced. While the frequency output is enabled, no alarm events are produced in either mode.

Top module: `time_match_alarm`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `alm_flag` is 2'b00 and `irq` is 0.
- R2: A match counts only in a cycle with `tick` high and `now_time` equal to that alarm's time. An equal time without `tick` produces no event. An event becomes visible on `alm_flag` and `irq` one clock after the sampled `tick`.
- R3: One-shot mode applies when `pulse_mode`=0. An enabled alarm fires on its first match, and later matches are ignored. The alarm re-arms once its `alm_en` bit has been 0 for at least one clock.
- R4: In one-shot mode both alarms may be enabled together, and each sets its own flag (bit 0 is alarm 0, bit 1 is alarm 1). Two events in the same cycle give a single one-cycle `irq` pulse.
- R5: Repeating mode applies when `pulse_mode`=1. An enabled alarm fires on every matching `tick`.
- R6: In repeating mode with `alm_en`=2'b11, alarm 1 produces no event and alarm 0 works normally.
- R7: While `fout_en`=1, no event is produced, and neither flag nor `irq` changes from an alarm match.
- R8: `sr_read_clr` clears both flags on the next clock. An event sampled in the same cycle sets its flag anyway, so the set wins over the clear.
- R9: `irq` is high for exactly one clock per event cycle and is otherwise low. A flag that stays set does not hold `irq` high.
- R10: In repeating mode, clearing an alarm's enable bit stops that alarm's events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-update strobe, one clock per time step |
| now_time | input | TIME_W | Current time value |
| alm0_time | input | TIME_W | Alarm 0 compare value |
| alm1_time | input | TIME_W | Alarm 1 compare value |
| alm_en | input | 2 | Per-alarm enable, bit i for alarm i |
| pulse_mode | input | 1 | 0 = one-shot, 1 = repeating |
| fout_en | input | 1 | Frequency output enabled; suppresses alarms |
| sr_read_clr | input | 1 | Strobe that clears both flags |
| alm_flag | output | 2 | Alarm status flags, bit i for alarm i |
| irq | output | 1 | One-cycle interrupt pulse per event cycle |

## Verification
The status-read clear and a new alarm event can land in the same clock. The bench provokes this by raising `sr_read_clr` in the very cycle that carries a matching `tick` in repeating mode, while the flag is already set. It then expects the flag to remain 1 and `irq` to pulse. The bench also gives a clear with no `tick` to show that the flag does drop. Both alarms firing in one cycle is a second collision, and it must merge into one `irq` pulse with both flag bits set.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NUM_ALM = 2;
  localparam int unsigned ALM_IDX_W = (NUM_ALM > 1) ? $clog2(NUM_ALM) : 1;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_REPEAT  = 1'b1
  } alm_mode_e;
endpackage

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int unsigned TIME_W = 24
) (
  input  logic              tick,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] target,
  output logic              hit
);
  // a match counts only on the update strobe, so one time step gives one hit
  always_comb hit = tick && (now_time == target);
endmodule

// File: rtl/alarm_arm_ctrl.sv
module alarm_arm_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned N = NUM_ALM
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  alm_mode_e    mode,
  input  logic         fout_en,
  input  logic [N-1:0] hit,
  output logic [N-1:0] fire
);
  logic [N-1:0] armed_q;
  logic [N-1:0] lower_en;

  // lower_en[i]: some alarm with higher priority (lower index) is enabled
  always_comb begin
    lower_en = '0;
    for (int i = 1; i < N; i++) lower_en[i] = lower_en[i-1] | en[i-1];
  end

  for (genvar g = 0; g < N; g++) begin : g_alm
    logic may_fire;
    always_comb begin
      if (mode == MODE_REPEAT) may_fire = !lower_en[g];
      else                     may_fire = armed_q[g];
    end
    always_comb fire[g] = !fout_en && en[g] && hit[g] && may_fire;

    always_ff @(posedge clk) begin
      if (rst)                                armed_q[g] <= 1'b1;
      else if (!en[g] || mode == MODE_REPEAT) armed_q[g] <= 1'b1;
      else if (fire[g])                       armed_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_status.sv
module alarm_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire,
  input  logic         clr,
  output logic [N-1:0] flag,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flag[g] <= 1'b0;
      else if (fire[g]) flag[g] <= 1'b1;
      else if (clr)     flag[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |fire;
  end
endmodule

// File: rtl/time_match_alarm.sv
module time_match_alarm
  import alarm_pkg::*;
#(
  parameter int unsigned TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] alm0_time,
  input  logic [TIME_W-1:0] alm1_time,
  input  logic [1:0]        alm_en,
  input  logic              pulse_mode,
  input  logic              fout_en,
  input  logic              sr_read_clr,
  output logic [1:0]        alm_flag,
  output logic              irq
);
  logic [TIME_W-1:0] targets [NUM_ALM];
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] fire;
  alm_mode_e          mode;

  always_comb begin
    targets[0] = alm0_time;
    targets[1] = alm1_time;
    mode = pulse_mode ? MODE_REPEAT : MODE_ONESHOT;
  end

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_cmp
    alarm_match_unit #(.TIME_W(TIME_W)) u_cmp (
      .tick(tick), .now_time(now_time), .target(targets[g]), .hit(hit[g])
    );
  end

  alarm_arm_ctrl #(.N(NUM_ALM)) u_arm (
    .clk(clk), .rst(rst), .en(alm_en), .mode(mode),
    .fout_en(fout_en), .hit(hit), .fire(fire)
  );

  alarm_status #(.N(NUM_ALM)) u_stat (
    .clk(clk), .rst(rst), .fire(fire), .clr(sr_read_clr),
    .flag(alm_flag), .irq(irq)
  );
endmodule

// File: rtl/time_match_alarm_chk.sv
module time_match_alarm_chk #(
  parameter int unsigned TIME_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [TIME_W-1:0] now_time,
  input logic [TIME_W-1:0] alm0_time,
  input logic [TIME_W-1:0] alm1_time,
  input logic [1:0]        alm_en,
  input logic              pulse_mode,
  input logic              fout_en,
  input logic              sr_read_clr,
  input logic [1:0]        alm_flag,
  input logic              irq
);
  assert_flag0_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alm_flag[0]) |-> $past(tick && now_time == alm0_time));
  assert_flag1_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alm_flag[1]) |-> $past(tick && now_time == alm1_time));
  assert_alm1_muted_R6: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && alm_en == 2'b11) |=> !$rose(alm_flag[1]));
  assert_fout_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(fout_en));
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (sr_read_clr && !tick) |=> (alm_flag == 2'b00));
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick && alm_en != 2'b00));
endmodule

bind time_match_alarm time_match_alarm_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .now_time(now_time),
  .alm0_time(alm0_time), .alm1_time(alm1_time), .alm_en(alm_en),
  .pulse_mode(pulse_mode), .fout_en(fout_en), .sr_read_clr(sr_read_clr),
  .alm_flag(alm_flag), .irq(irq)
);

// File: tb/sim_time_match_alarm.sv
`timescale 1ns/1ps
module sim_time_match_alarm;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [TW-1:0] now_time = '0, alm0_time = '0, alm1_time = '0;
  logic [1:0] alm_en = 2'b00;
  logic pulse_mode = 1'b0, fout_en = 1'b0, sr_read_clr = 1'b0;
  logic [1:0] alm_flag;
  logic irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  time_match_alarm #(.TIME_W(TW)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .now_time(now_time),
    .alm0_time(alm0_time), .alm1_time(alm1_time), .alm_en(alm_en),
    .pulse_mode(pulse_mode), .fout_en(fout_en), .sr_read_clr(sr_read_clr),
    .alm_flag(alm_flag), .irq(irq)
  );

  // behavioural reference model
  bit [1:0] m_flag, m_arm;
  bit m_irq;
  always @(posedge clk) begin
    bit h0, h1, f0, f1;
    if (rst) begin
      m_flag = 2'b00; m_irq = 0; m_arm = 2'b11;
    end else begin
      h0 = tick && (now_time == alm0_time);
      h1 = tick && (now_time == alm1_time);
      if (pulse_mode) begin
        f0 = h0 && alm_en[0];
        f1 = h1 && alm_en[1] && !alm_en[0];
      end else begin
        f0 = h0 && alm_en[0] && m_arm[0];
        f1 = h1 && alm_en[1] && m_arm[1];
      end
      if (fout_en) begin f0 = 0; f1 = 0; end
      m_arm[0] = (!alm_en[0] || pulse_mode) ? 1'b1 : (f0 ? 1'b0 : m_arm[0]);
      m_arm[1] = (!alm_en[1] || pulse_mode) ? 1'b1 : (f1 ? 1'b0 : m_arm[1]);
      m_flag[0] = f0 ? 1'b1 : (sr_read_clr ? 1'b0 : m_flag[0]);
      m_flag[1] = f1 ? 1'b1 : (sr_read_clr ? 1'b0 : m_flag[1]);
      m_irq = f0 || f1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "model alm_flag", alm_flag, m_flag);
      check(cur_req, "model irq", irq, m_irq);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one tick at time t; returns at the negedge where the result is visible
  task automatic tick_at(logic [TW-1:0] t, bit clr = 0);
    @(negedge clk);
    now_time = t; tick = 1; sr_read_clr = clr;
    @(negedge clk);
    tick = 0; sr_read_clr = 0;
    #1;
  endtask

  task automatic clear_flags();
    @(negedge clk); sr_read_clr = 1;
    @(negedge clk); sr_read_clr = 0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", "flag in reset", alm_flag, 0);
    check("R1", "irq in reset", irq, 0);
    @(negedge clk); rst = 0;
    #1;
    check("R1", "flag after reset", alm_flag, 0);

    // R2: match needs tick
    cur_req = "R2";
    alm0_time = 100; alm1_time = 200; alm_en = 2'b01;
    @(negedge clk); now_time = 100; idle(3);
    check("R2", "no tick no flag", alm_flag, 0);
    tick_at(50);
    check("R2", "mismatch no flag", alm_flag, 0);
    tick_at(100);
    check("R2", "match sets flag0", alm_flag, 1);
    check("R9", "irq pulse", irq, 1);
    @(negedge clk); #1;
    cur_req = "R9";
    check("R9", "irq drops", irq, 0);

    // R3: one-shot disarms
    cur_req = "R3";
    clear_flags();
    tick_at(100);
    check("R3", "second match ignored", alm_flag, 0);
    check("R3", "no irq", irq, 0);
    @(negedge clk); alm_en = 2'b00;
    @(negedge clk); alm_en = 2'b01;
    tick_at(100);
    check("R3", "re-armed fires", alm_flag, 1);

    // R4: both one-shot, same cycle
    cur_req = "R4";
    clear_flags();
    @(negedge clk); alm_en = 2'b00; alm0_time = 300; alm1_time = 300;
    @(negedge clk); alm_en = 2'b11;
    tick_at(300);
    check("R4", "both flags", alm_flag, 3);
    check("R4", "single irq", irq, 1);
    @(negedge clk); #1;
    check("R4", "irq one cycle", irq, 0);

    // R8: clear, and clear/set collision
    cur_req = "R8";
    clear_flags();
    check("R8", "cleared", alm_flag, 0);
    @(negedge clk); alm_en = 2'b01; pulse_mode = 1; alm0_time = 400;
    tick_at(400);
    check("R8", "set before collision", alm_flag, 1);
    tick_at(400, 1);
    check("R8", "set wins over clear", alm_flag, 1);
    check("R8", "irq on collision", irq, 1);

    // R5: repeating fires every match
    cur_req = "R5";
    for (int k = 0; k < 3; k++) begin
      clear_flags();
      tick_at(400);
      check("R5", "repeat flag", alm_flag, 1);
      check("R5", "repeat irq", irq, 1);
    end

    // R6: alarm 0 priority
    cur_req = "R6";
    clear_flags();
    @(negedge clk); alm_en = 2'b11; alm1_time = 500;
    tick_at(500);
    check("R6", "alarm1 muted", alm_flag, 0);
    check("R6", "no irq", irq, 0);
    tick_at(400);
    check("R6", "alarm0 works", alm_flag, 1);

    // R7: frequency output suppresses
    cur_req = "R7";
    clear_flags();
    @(negedge clk); fout_en = 1; alm_en = 2'b01;
    tick_at(400);
    check("R7", "no flag", alm_flag, 0);
    check("R7", "no irq", irq, 0);
    @(negedge clk); fout_en = 0; pulse_mode = 0; alm_en = 2'b00;
    @(negedge clk); alm_en = 2'b10;
    tick_at(500);
    check("R7", "alarm1 one-shot ok after fout off", alm_flag, 2);

    // R10: clearing enable stops repeating
    cur_req = "R10";
    clear_flags();
    @(negedge clk); pulse_mode = 1; alm_en = 2'b01;
    tick_at(400);
    check("R10", "fires while enabled", alm_flag, 1);
    clear_flags();
    @(negedge clk); alm_en = 2'b00;
    tick_at(400);
    check("R10", "stopped", alm_flag, 0);
    check("R10", "no irq", irq, 0);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule